// File: doc/BRIEF.md
# Delayed-Branch Pipeline Sequencer

This block sequences a short in-order pipeline. Register-to-register instructions take two phases: a fetch, then an execute phase that reads operands, does the ALU work and writes the result. Loads and stores take a third phase for the data transfer itself. The sequencer drives the instruction fetch address. It is told the class of the instruction now in execute, whether a branch there is taken, and where the branch goes. It reports the address of the instruction held in each phase.

Instruction and data traffic share one memory port, so only one access can happen per cycle. A data transfer always wins the port. In that cycle fetch is held and the fetch address stays where it is. Branches have a single delay slot. The instruction fetched right after a branch always goes on to execute, and the fetch address moves to the target only once that slot has been fetched. The sequencer never throws away a fetched instruction, so it has no flush logic.

Top module: `seq_ctrl`

## Requirements
- R1: After reset the fetch address is 0, fetch is enabled, and both the execute and memory phases hold bubbles (valid low).
- R2: When no redirect is due and the port is free, each cycle's fetch address is the previous fetch address plus one.
- R3: An instruction fetched in cycle t is in the execute phase in cycle t+1, with its own address. A cycle with no fetch leaves a bubble in execute in the next cycle.
- R4: Class codes are 00 ALU (also used for no-op), 01 load, 10 store, 11 branch. A load or store in execute in cycle t is in the memory phase in cycle t+1 with its address. The data-port select is high in that cycle, and the write flag is high only for a store.
- R5: In a memory-phase cycle the fetch enable is low and the fetch address does not change.
- R6: An ALU or branch instruction in execute never produces a memory phase in the next cycle.
- R7: For a taken branch in execute, the fetch in that same cycle is the delay slot, at the branch address plus one. That slot then executes, and the next fetch goes to the target.
- R8: A branch that is not taken leaves the fetch address on the sequential path.
- R9: If a taken branch is in execute while fetch is held by a memory phase, the delay slot is fetched in the next cycle, and the target is fetched in the cycle after that.
- R10: A branch sitting in a delay slot acts as an ordinary branch. Its own delay slot is the first instruction fetched at the earlier branch's target.
- R11: The class, taken and target inputs are ignored while the execute phase holds a bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_cls_i | input | 2 | Class of the instruction in execute (00 ALU, 01 load, 10 store, 11 branch) |
| br_taken_i | input | 1 | Branch in execute is taken |
| br_target_i | input | AW | Target address of the branch in execute |
| fetch_en_o | output | 1 | Memory port performs an instruction fetch this cycle |
| fetch_addr_o | output | AW | Instruction fetch address |
| dmem_sel_o | output | 1 | Memory port performs a data transfer this cycle |
| dmem_write_o | output | 1 | Data transfer is a store |
| ex_vld_o | output | 1 | Execute phase holds a real instruction |
| ex_addr_o | output | AW | Address of the instruction in execute |
| mem_vld_o | output | 1 | Memory phase holds a load or store |
| mem_addr_o | output | AW | Address of the instruction in the memory phase |

## Verification
The assertions check on every cycle that a load or store in execute takes the port in the next cycle, that a held fetch keeps its address, that each fetch shows up in execute one cycle later, that a taken branch with a fetch in the same cycle moves the next fetch to the target, and that ALU and branch instructions never enter the memory phase. Only the bench scenarios can show the whole ordering of fetch addresses. That covers a redirect left pending across a held fetch, a branch in a delay slot handing its own slot to the first target instruction, and inputs being ignored during bubbles. The bench checks these in a directed trace and in a sweep over many generated instruction streams.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    CLS_ALU    = 2'b00,
    CLS_LOAD   = 2'b01,
    CLS_STORE  = 2'b10,
    CLS_BRANCH = 2'b11
  } ins_cls_e;

  function automatic logic needs_mem(input ins_cls_e c);
    return (c == CLS_LOAD) || (c == CLS_STORE);
  endfunction

  function automatic logic is_taken_branch(input logic vld, input ins_cls_e c, input logic tk);
    return vld && (c == CLS_BRANCH) && tk;
  endfunction
endpackage

// File: rtl/seq_port_arb.sv
module seq_port_arb (
  input  logic mem_vld_i,
  output logic fetch_go_o,
  output logic dmem_sel_o
);
  // The data transfer always owns the shared port; fetch gets what is left.
  assign dmem_sel_o = mem_vld_i;
  assign fetch_go_o = ~mem_vld_i;
endmodule

// File: rtl/seq_fetch.sv
module seq_fetch #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic          redir_now_i,
  input  logic [AW-1:0] redir_tgt_i,
  output logic [AW-1:0] pc_o
);
  logic          pend_q;
  logic [AW-1:0] pend_tgt_q;

  // Address after a completed fetch: a redirect seen now or one left
  // pending from a held cycle beats the sequential step.
  function automatic logic [AW-1:0] after_fetch(
    input logic [AW-1:0] pc, input logic now_v, input logic [AW-1:0] now_t,
    input logic pend_v, input logic [AW-1:0] pend_t);
    if (now_v)       return now_t;
    else if (pend_v) return pend_t;
    else             return pc + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_o       <= '0;
      pend_q     <= 1'b0;
      pend_tgt_q <= '0;
    end else if (go_i) begin
      pc_o   <= after_fetch(pc_o, redir_now_i, redir_tgt_i, pend_q, pend_tgt_q);
      pend_q <= 1'b0;
    end else if (redir_now_i) begin
      pend_q     <= 1'b1;
      pend_tgt_q <= redir_tgt_i;
    end
  end

  // R5: a held fetch keeps its address
  assert_hold_on_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !go_i |=> pc_o == $past(pc_o));

  // R9: a pending redirect is resolved by the next completed fetch
  assert_pending_resolves_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && go_i) |=> (pc_o == $past(pend_tgt_q)) && !pend_q);
endmodule

// File: rtl/seq_phases.sv
module seq_phases #(
  parameter int AW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_go_i,
  input  logic [AW-1:0]      pc_i,
  input  seq_pkg::ins_cls_e  ex_cls_i,
  output logic               ex_vld_o,
  output logic [AW-1:0]      ex_pc_o,
  output logic               mem_vld_o,
  output logic [AW-1:0]      mem_pc_o,
  output logic               mem_wr_o
);
  import seq_pkg::*;

  logic ex_to_mem;
  assign ex_to_mem = ex_vld_o && needs_mem(ex_cls_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_vld_o  <= 1'b0;
      ex_pc_o   <= '0;
      mem_vld_o <= 1'b0;
      mem_pc_o  <= '0;
      mem_wr_o  <= 1'b0;
    end else begin
      ex_vld_o  <= fetch_go_i;
      if (fetch_go_i) ex_pc_o <= pc_i;
      mem_vld_o <= ex_to_mem;
      mem_pc_o  <= ex_pc_o;
      mem_wr_o  <= ex_to_mem && (ex_cls_i == CLS_STORE);
    end
  end

  // R4: memory phase carries the address of the instruction that was in execute
  assert_mem_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ex_to_mem |=> mem_vld_o && (mem_pc_o == $past(ex_pc_o)));

  // R4: write flag only accompanies a valid memory phase
  assert_write_needs_mem_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> mem_vld_o);
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    ex_cls_i,
  input  logic          br_taken_i,
  input  logic [AW-1:0] br_target_i,
  output logic          fetch_en_o,
  output logic [AW-1:0] fetch_addr_o,
  output logic          dmem_sel_o,
  output logic          dmem_write_o,
  output logic          ex_vld_o,
  output logic [AW-1:0] ex_addr_o,
  output logic          mem_vld_o,
  output logic [AW-1:0] mem_addr_o
);
  import seq_pkg::*;

  ins_cls_e cls;
  logic     redir_now;
  logic     fetch_go;
  logic     mem_wr;

  assign cls       = ins_cls_e'(ex_cls_i);
  assign redir_now = is_taken_branch(ex_vld_o, cls, br_taken_i);

  seq_port_arb u_arb (
    .mem_vld_i  (mem_vld_o),
    .fetch_go_o (fetch_go),
    .dmem_sel_o (dmem_sel_o)
  );

  seq_fetch #(.AW(AW)) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_i        (fetch_go),
    .redir_now_i (redir_now),
    .redir_tgt_i (br_target_i),
    .pc_o        (fetch_addr_o)
  );

  seq_phases #(.AW(AW)) u_phases (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_go_i (fetch_go),
    .pc_i       (fetch_addr_o),
    .ex_cls_i   (cls),
    .ex_vld_o   (ex_vld_o),
    .ex_pc_o    (ex_addr_o),
    .mem_vld_o  (mem_vld_o),
    .mem_pc_o   (mem_addr_o),
    .mem_wr_o   (mem_wr)
  );

  assign fetch_en_o   = fetch_go;
  assign dmem_write_o = mem_wr;

  // R5: load or store in execute takes the port from fetch next cycle
  assert_ls_blocks_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_vld_o && needs_mem(cls)) |=> !fetch_en_o && dmem_sel_o);

  // R3: every fetch reaches execute one cycle later with its address
  assert_fetch_enters_ex_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en_o |=> ex_vld_o && (ex_addr_o == $past(fetch_addr_o)));

  // R3: a cycle without fetch leaves a bubble in execute
  assert_bubble_after_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_en_o |=> !ex_vld_o);

  // R7: taken branch with delay slot fetched now sends the next fetch to the target
  assert_taken_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en_o && redir_now) |=> fetch_addr_o == $past(br_target_i));

  // R6: ALU and branch instructions never enter the memory phase
  assert_no_mem_for_alu_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_vld_o && !needs_mem(cls)) |=> !mem_vld_o);
endmodule

// File: tb/seq_ctrl_bench.sv
`timescale 1ns/1ps
module seq_ctrl_bench;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    ex_cls;
  logic          br_taken;
  logic [AW-1:0] br_target;
  logic          fetch_en, dmem_sel, dmem_write, ex_vld, mem_vld;
  logic [AW-1:0] fetch_addr, ex_addr, mem_addr;

  always #4 clk = ~clk;

  seq_ctrl #(.AW(AW)) u_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .ex_cls_i(ex_cls), .br_taken_i(br_taken),
    .br_target_i(br_target), .fetch_en_o(fetch_en), .fetch_addr_o(fetch_addr),
    .dmem_sel_o(dmem_sel), .dmem_write_o(dmem_write), .ex_vld_o(ex_vld),
    .ex_addr_o(ex_addr), .mem_vld_o(mem_vld), .mem_addr_o(mem_addr)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Instruction stream: class, taken flag and target as functions of address.
  function automatic logic [1:0] cls_at(input int s, input int a);
    int h;
    if (s == 0) begin
      case (a)
        1:         return 2'b01;
        2, 3, 20:  return 2'b11;
        default:   return 2'b00;
      endcase
    end
    h = (a * 37 + s * 101 + (a / 2) * s) % 9;
    if (h < 4) return 2'b00;
    if (h < 6) return 2'b01;
    if (h < 7) return 2'b10;
    return 2'b11;
  endfunction

  function automatic logic tk_at(input int s, input int a);
    if (s == 0) return 1'b1;
    return ((a * 3 + s) % 4) != 0;
  endfunction

  function automatic logic [AW-1:0] tgt_at(input int s, input int a);
    if (s == 0) begin
      if (a == 2)  return AW'(20);
      if (a == 3)  return AW'(30);
      if (a == 20) return AW'(40);
      return '0;
    end
    return AW'((a * 11 + s * 7) % 48);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bench view of the pipeline: what should be in each phase this cycle.
  logic          m_fe, m_exv, m_memv, m_memw, m_pend;
  logic [AW-1:0] m_pc, m_expc, m_mempc, m_ptgt;

  task automatic run_stream(input int s, input int ncyc);
    logic brk;
    logic [AW-1:0] t_next;
    int exp_a [9] = '{0, 1, 2, 3, 3, 20, 30, 40, 41};
    bit exp_f [9] = '{1, 1, 1, 0, 1, 1, 1, 1, 1};
    rst_n = 1'b0;
    ex_cls = 2'b00; br_taken = 1'b0; br_target = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_pc = '0; m_exv = 0; m_memv = 0; m_memw = 0; m_pend = 0;
    m_expc = '0; m_mempc = '0; m_ptgt = '0;
    if (s == 0) begin
      check(fetch_en == 1'b1, "R1 fetch_en", int'(fetch_en), 1);
      check(fetch_addr == '0, "R1 fetch_addr", int'(fetch_addr), 0);
      check(!ex_vld && !mem_vld, "R1 phases empty", int'(ex_vld) + int'(mem_vld), 0);
    end
    for (int k = 0; k < ncyc; k++) begin
      m_fe = !m_memv;
      // compare ports with the expected phase contents
      check(fetch_en == m_fe, "R5 fetch_en", int'(fetch_en), int'(m_fe));
      if (m_fe) check(fetch_addr == m_pc, "R2 R7 R8 fetch_addr", int'(fetch_addr), int'(m_pc));
      else      check(fetch_addr == m_pc, "R5 held addr", int'(fetch_addr), int'(m_pc));
      check(ex_vld == m_exv, "R3 ex_vld", int'(ex_vld), int'(m_exv));
      if (m_exv) check(ex_addr == m_expc, "R3 ex_addr", int'(ex_addr), int'(m_expc));
      check(mem_vld == m_memv, "R4 R6 mem_vld", int'(mem_vld), int'(m_memv));
      check(dmem_sel == m_memv, "R4 dmem_sel", int'(dmem_sel), int'(m_memv));
      check(dmem_write == m_memw, "R4 dmem_write", int'(dmem_write), int'(m_memw));
      if (m_memv) check(mem_addr == m_mempc, "R4 mem_addr", int'(mem_addr), int'(m_mempc));
      if (s == 0 && k < 9) begin
        check(fetch_en == exp_f[k], "R9 R10 trace fetch_en", int'(fetch_en), int'(exp_f[k]));
        check(fetch_addr == AW'(exp_a[k]), "R9 R10 trace fetch_addr", int'(fetch_addr), exp_a[k]);
      end
      if (s == 0 && k == 1)
        check(!mem_vld && fetch_addr == AW'(1), "R11 bubble inputs ignored", int'(mem_vld), 0);
      // drive the execute-phase description
      if (m_exv) begin
        ex_cls = cls_at(s, int'(m_expc));
        br_taken = tk_at(s, int'(m_expc));
        br_target = tgt_at(s, int'(m_expc));
      end else begin
        ex_cls = 2'b01; br_taken = 1'b1; br_target = AW'(16'h55); // R11 stimulus
      end
      // what the next cycle should look like
      brk = m_exv && ex_cls == 2'b11 && br_taken;
      if (m_fe) begin
        if (brk)         t_next = br_target;
        else if (m_pend) t_next = m_ptgt;
        else             t_next = m_pc + AW'(1);
        m_pend = 1'b0;
      end else begin
        t_next = m_pc;
        if (brk) begin m_pend = 1'b1; m_ptgt = br_target; end
      end
      m_memw  = m_exv && ex_cls == 2'b10;
      m_memv  = m_exv && (ex_cls == 2'b01 || ex_cls == 2'b10);
      m_mempc = m_expc;
      m_exv   = m_fe;
      if (m_fe) m_expc = m_pc;
      m_pc    = t_next;
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    for (int s = 0; s < 40; s++) run_stream(s, 80);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule